// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the receive-side front end of a network DMA. Software builds a ring of 8-byte descriptors in memory. Each descriptor names a data buffer and carries an ownership flag. The engine takes a byte stream of frames from the MAC, places each frame in the buffer of the current descriptor, and then writes the descriptor back with the stored length and the frame status. Ownership passes back to software when the engine clears the empty flag.

The ring has no fixed size. The engine steps to the next descriptor after each frame, and it returns to the ring base after the descriptor whose wrap flag is set. If the engine finds a descriptor that software has not yet released, it turns itself off and holds the pending frame. It does not look at the ring again until software writes a 1 to bit 24 of the re-arm port. After that write it fetches the same descriptor again.

The frame stream uses a valid/ready handshake. A byte moves on any rising edge where `rx_valid` and `rx_ready` are both high. The producer must keep `rx_data`, `rx_last`, `rx_err`, `rx_bcast` and `rx_mcast` stable while `rx_valid` is high and `rx_ready` is low. The engine lowers `rx_ready` during every memory access, while it is parked, and between frames. The memory port also uses a request/ready handshake. A request holds its address, data and byte enables until `mem_ready` is high. Read data returns with `mem_rvalid` one cycle after the read is accepted.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is inactive and its ring index is 0. It issues no memory request and keeps `rx_ready` low until it is armed, even while `rx_valid` is high.
- R2: A write on the re-arm port with bit 24 set makes the engine active. A write with bit 24 clear has no effect.
- R3: Descriptor n lives at B + 8*n, where B is `cfg_ring_base` with its low 4 bits forced to zero. The word at offset 0 carries the length in bits 15:0 and the status in bits 31:16. The word at offset 4 is the buffer pointer.
- R4: When the fetched status does not have bit 15 (empty) set, the engine goes inactive. It consumes no frame byte, writes nothing, and only re-reads the same descriptor after a new arm.
- R5: Frame byte i is written to pointer + i, where the pointer has its low 2 bits forced to zero. The write is a little-endian 32-bit word access whose byte enables cover only the bytes that were stored, so the other bytes of a partial word are left unchanged.
- R6: The write-back length is the number of bytes stored, with the trailing CRC bytes included. The write-back status has bit 15 clear, bit 11 (end of frame) set, and bit 13 (wrap) copied from the fetched status.
- R7: The frame error flags `rx_err[4:0]` are sampled with the last byte and reported in these status bits: rx_err[4] to bit 5 (length violation), rx_err[3] to bit 4 (non-octet), rx_err[2] to bit 2 (CRC), rx_err[1] to bit 1 (overrun) and rx_err[0] to bit 0 (truncation).
- R8: `rx_bcast` sets status bit 7 and `rx_mcast` sets status bit 6, both sampled with the last byte.
- R9: Bytes beyond `cfg_buf_max` are consumed but not stored. In that case the length is `cfg_buf_max` and status bit 0 is set. A frame of exactly `cfg_buf_max` bytes is not flagged.
- R10: After a write-back the index moves to n+1, or to 0 if the wrap bit was set in the fetched status.
- R11: A memory request stays asserted, with address, direction, data and byte enables unchanged, until `mem_ready` accepts it. Every request address is word aligned and every write has at least one byte enable set.
- R12: `rx_ready` is high only while the engine is filling a buffer, and it is never high in a cycle with a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 32 | Descriptor ring base address (low 4 bits ignored) |
| cfg_buf_max | input | 16 | Maximum bytes stored per buffer |
| arm_we | input | 1 | Write strobe of the re-arm register |
| arm_wdata | input | 32 | Re-arm write data; bit 24 arms |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Engine accepts a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of the frame |
| rx_err | input | 5 | Frame error flags, valid with last byte |
| rx_bcast | input | 1 | Broadcast frame, valid with last byte |
| rx_mcast | input | 1 | Multicast frame, valid with last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data, little-endian |
| mem_be | output | 4 | Write byte enables |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume three things about the memory. It returns exactly one `mem_rvalid` pulse for each accepted read, it never sends one unprompted, and its data pointers are word aligned. They also assume the frame producer honours the hold rule above. The bench memory model answers each accepted read exactly one cycle later and gates `mem_ready` with a pseudo-random pattern, so every request is tested against stalls. The bench places all buffers on word boundaries and changes frame inputs only on falling edges, after it has seen `rx_ready`.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int AW         = 32;
  localparam int DW         = 32;
  localparam int LENW       = 16;
  localparam int NLANE      = DW / 8;
  localparam int LANEW      = $clog2(NLANE);
  localparam int ERRW       = 5;
  localparam int RING_ALIGN = 4;   // ring base aligned to 2**RING_ALIGN bytes
  localparam int DESC_SHIFT = 3;   // 8-byte descriptors
  localparam int ARM_BIT    = 24;

  // status bit positions (upper half of descriptor word 0)
  localparam int SB_EMPTY = 15;
  localparam int SB_WRAP  = 13;
  localparam int SB_LAST  = 11;
  localparam int SB_BC    = 7;
  localparam int SB_MC    = 6;
  localparam int SB_LG    = 5;
  localparam int SB_NO    = 4;
  localparam int SB_CR    = 2;
  localparam int SB_OV    = 1;
  localparam int SB_TR    = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_STAT, ST_WT_STAT, ST_RD_PTR, ST_WT_PTR, ST_FILL, ST_WR_DATA, ST_WR_BACK
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring.sv
module rxr_ring
  import rxr_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          arm,
  input  logic          park,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] desc_addr,
  output logic          active
);
  localparam int OFFW = IDX_W + DESC_SHIFT;

  logic [IDX_W-1:0] idx_q;
  logic             active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (advance) idx_q <= wrap ? '0 : idx_q + 1'b1;
      if (arm)       active_q <= 1'b1;
      else if (park) active_q <= 1'b0;
    end
  end

  logic [OFFW-1:0] off;
  assign off       = {idx_q, {DESC_SHIFT{1'b0}}};
  assign desc_addr = {ring_base[AW-1:RING_ALIGN], {RING_ALIGN{1'b0}}} + AW'(off);
  assign active    = active_q;
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put,
  input  logic [LANEW-1:0] lane,
  input  logic [7:0]       din,
  input  logic             clr,
  output logic [DW-1:0]    word,
  output logic [NLANE-1:0] be
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word[g*8 +: 8] <= '0;
        be[g]          <= 1'b0;
      end else if (clr) begin
        be[g] <= 1'b0;
      end else if (put && lane == LANEW'(g)) begin
        word[g*8 +: 8] <= din;
        be[g]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cfg_ring_base,
  input  logic [LENW-1:0]  cfg_buf_max,
  input  logic             arm_we,
  input  logic [31:0]      arm_wdata,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [ERRW-1:0]  rx_err,
  input  logic             rx_bcast,
  input  logic             rx_mcast,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [NLANE-1:0] mem_be,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata
);
  rxr_state_e st, nst;

  logic            wrap_q, trunc_q, done_q, bc_q, mc_q;
  logic [ERRW-1:0] err_q;
  logic [AW-1:0]   buf_ptr;
  logic [LENW-1:0] byte_cnt;

  logic            arm_hit, active, park, advance;
  logic [AW-1:0]   desc_addr;
  logic            unused_arm_bits;

  assign arm_hit         = arm_we && arm_wdata[ARM_BIT];
  assign unused_arm_bits = ^{arm_wdata[31:ARM_BIT+1], arm_wdata[ARM_BIT-1:0]};

  // descriptor status as read back
  logic rd_empty;
  assign rd_empty = mem_rdata[16 + SB_EMPTY];
  assign park     = (st == ST_WT_STAT) && mem_rvalid && !rd_empty;
  assign advance  = (st == ST_WR_BACK) && mem_ready;

  rxr_ring #(.IDX_W(IDX_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (cfg_ring_base),
    .arm       (arm_hit),
    .park      (park),
    .advance   (advance),
    .wrap      (wrap_q),
    .desc_addr (desc_addr),
    .active    (active)
  );

  // byte handling
  logic             accept, store_now, pk_put, pk_clr, go_wr;
  logic [LANEW-1:0] lane;
  logic [DW-1:0]    pk_word;
  logic [NLANE-1:0] pk_be;

  assign rx_ready  = (st == ST_FILL);
  assign accept    = rx_ready && rx_valid;
  assign store_now = byte_cnt < cfg_buf_max;
  assign lane      = byte_cnt[LANEW-1:0];
  assign pk_put    = accept && store_now;
  assign pk_clr    = (st == ST_WR_DATA) && mem_ready;
  assign go_wr     = accept && ((pk_put && lane == LANEW'(NLANE-1)) ||
                                (rx_last && (pk_put || pk_be != '0)));

  rxr_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .put   (pk_put),
    .lane  (lane),
    .din   (rx_data),
    .clr   (pk_clr),
    .word  (pk_word),
    .be    (pk_be)
  );

  // next state
  always_comb begin
    nst = st;
    unique case (st)
      ST_IDLE:    if (active && rx_valid) nst = ST_RD_STAT;
      ST_RD_STAT: if (mem_ready) nst = ST_WT_STAT;
      ST_WT_STAT: if (mem_rvalid) nst = rd_empty ? ST_RD_PTR : ST_IDLE;
      ST_RD_PTR:  if (mem_ready) nst = ST_WT_PTR;
      ST_WT_PTR:  if (mem_rvalid) nst = ST_FILL;
      ST_FILL:    if (accept) nst = go_wr ? ST_WR_DATA : (rx_last ? ST_WR_BACK : ST_FILL);
      ST_WR_DATA: if (mem_ready) nst = done_q ? ST_WR_BACK : ST_FILL;
      ST_WR_BACK: if (mem_ready) nst = ST_IDLE;
      default:    nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wrap_q   <= 1'b0;
      trunc_q  <= 1'b0;
      done_q   <= 1'b0;
      bc_q     <= 1'b0;
      mc_q     <= 1'b0;
      err_q    <= '0;
      buf_ptr  <= '0;
      byte_cnt <= '0;
    end else begin
      st <= nst;
      if (st == ST_WT_STAT && mem_rvalid && rd_empty)
        wrap_q <= mem_rdata[16 + SB_WRAP];
      if (st == ST_WT_PTR && mem_rvalid) begin
        buf_ptr  <= mem_rdata & ~AW'(NLANE - 1);
        byte_cnt <= '0;
        trunc_q  <= 1'b0;
        done_q   <= 1'b0;
        err_q    <= '0;
        bc_q     <= 1'b0;
        mc_q     <= 1'b0;
      end
      if (accept) begin
        if (store_now) byte_cnt <= byte_cnt + 1'b1;
        else           trunc_q  <= 1'b1;
        if (rx_last) begin
          done_q <= 1'b1;
          err_q  <= rx_err;
          bc_q   <= rx_bcast;
          mc_q   <= rx_mcast;
        end
      end
    end
  end

  // write-back word
  logic [15:0]     wb_status;
  logic [LENW-1:0] last_pos;
  logic [AW-1:0]   data_addr;

  always_comb begin
    wb_status          = '0;
    wb_status[SB_LAST] = 1'b1;
    wb_status[SB_WRAP] = wrap_q;
    wb_status[SB_BC]   = bc_q;
    wb_status[SB_MC]   = mc_q;
    wb_status[SB_LG]   = err_q[4];
    wb_status[SB_NO]   = err_q[3];
    wb_status[SB_CR]   = err_q[2];
    wb_status[SB_OV]   = err_q[1];
    wb_status[SB_TR]   = err_q[0] | trunc_q;
  end

  assign last_pos  = byte_cnt - 1'b1;
  assign data_addr = buf_ptr + AW'({last_pos[LENW-1:LANEW], {LANEW{1'b0}}});

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (st)
      ST_RD_STAT: mem_req = 1'b1;
      ST_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
      end
      ST_WR_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = data_addr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WR_BACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {wb_status, byte_cnt};
        mem_be    = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxr_check.sv
module rxr_check
  import rxr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             arm_hit,
  input logic             active,
  input logic             rx_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic [NLANE-1:0] mem_be
);
  assert_arm_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> active);

  assert_parked_holds_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !rx_ready);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                              $stable(mem_wdata) && $stable(mem_be));

  assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[LANEW-1:0] == '0);

  assert_write_has_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != '0);

  assert_no_ready_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req);
endmodule

bind rx_ring_engine rxr_check u_rxr_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_hit   (arm_hit),
  .active    (active),
  .rx_ready  (rx_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be)
);

// File: tb/rx_ring_engine_test.sv
`timescale 1ns/1ps
module rx_ring_engine_test;
  localparam bit [31:0] RING_CFG = 32'h0000_1003; // low bits must be ignored
  localparam bit [31:0] RING     = 32'h0000_1000;
  localparam bit [31:0] BUF0     = 32'h0000_4000;
  localparam int        BUFMAX   = 20;
  localparam int        NDESC    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        arm_we = 0;
  logic [31:0] arm_wdata = 0;
  logic        rx_valid = 0, rx_last = 0, rx_bcast = 0, rx_mcast = 0;
  logic [7:0]  rx_data = 0;
  logic [4:0]  rx_err = 0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  rx_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(RING_CFG), .cfg_buf_max(16'(BUFMAX)),
    .arm_we(arm_we), .arm_wdata(arm_wdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  bit [31:0] mem [int unsigned];

  function automatic bit [31:0] rd32(input bit [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  function automatic bit [7:0] rd8(input bit [31:0] a);
    bit [31:0] w = rd32(a);
    return w[8*(a%4) +: 8];
  endfunction

  task automatic wr32(input bit [31:0] a, input bit [31:0] d, input bit [3:0] be);
    bit [31:0] w = rd32(a);
    for (int k = 0; k < 4; k++) if (be[k]) w[8*k +: 8] = d[8*k +: 8];
    mem[a >> 2] = w;
  endtask

  typedef struct {
    bit [31:0] dsc;
    bit [31:0] wb;
    bit [31:0] buf_a;
    int        n;
    bit [7:0]  seed;
    string     tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic on_writeback(input bit [31:0] a, input bit [31:0] d);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R4 unexpected write-back", a, 32'h0);
      return;
    end
    e = exp_q.pop_front();
    check(a == e.dsc, {e.tag, " R10 descriptor address"}, a, e.dsc);
    check(d == e.wb, {e.tag, " R6 write-back word"}, d, e.wb);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < e.n; i++) if (rd8(e.buf_a + i) != 8'(e.seed + i)) ok = 1'b0;
      check(ok, {e.tag, " R5 buffer bytes"}, rd32(e.buf_a), {8'(e.seed+3), 8'(e.seed+2), 8'(e.seed+1), e.seed});
    end
    check(rd8(e.buf_a + e.n) == 8'hA5, {e.tag, " R5 R9 byte after frame untouched"},
          32'(rd8(e.buf_a + e.n)), 32'hA5);
  endtask

  bit [7:0]  lf = 8'h5B;
  bit        rd_pend = 0;
  bit [31:0] rd_word = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 0;
      mem_ready  = 0;
      rd_pend    = 0;
    end else begin
      lf         = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_rvalid = rd_pend;
      mem_rdata  = rd_word;
      mem_ready  = lf[0] | lf[2];
      rd_pend    = 0;
      if (mem_req && mem_ready) begin
        if (!mem_we) begin
          rd_pend = 1;
          rd_word = rd32(mem_addr);
        end else begin
          wr32(mem_addr, mem_wdata, mem_be);
          if (mem_addr >= RING && mem_addr < RING + 8*NDESC && !mem_addr[2])
            on_writeback(mem_addr, mem_wdata);
        end
      end
    end
  end

  task automatic init_desc(input int i);
    bit [15:0] st = 16'h8000 | ((i == NDESC-1) ? 16'h2000 : 16'h0);
    mem[(RING + 8*i) >> 2]     = {st, 16'h0};
    mem[(RING + 8*i + 4) >> 2] = BUF0 + 32'h100 * i;
    for (int k = 0; k < 8; k++) mem[(BUF0 + 32'h100*i) / 4 + k] = 32'hA5A5_A5A5;
  endtask

  task automatic arm(input bit [31:0] d);
    @(negedge clk);
    arm_we = 1; arm_wdata = d;
    @(negedge clk);
    arm_we = 0; arm_wdata = 0;
  endtask

  task automatic send_frame(input int di, input int len, input bit [7:0] seed,
                            input bit [4:0] err, input bit bc, input bit mc, input string tag);
    exp_t e;
    int stored = (len > BUFMAX) ? BUFMAX : len;
    bit [15:0] st = 16'h0800;
    if (di == NDESC-1) st |= 16'h2000;
    if (bc) st |= 16'h0080;
    if (mc) st |= 16'h0040;
    st |= {10'b0, err[4], err[3], 1'b0, err[2], err[1], err[0] | (len > BUFMAX)};
    e.dsc = RING + 8*di; e.wb = {st, 16'(stored)}; e.buf_a = BUF0 + 32'h100*di;
    e.n = stored; e.seed = seed; e.tag = tag;
    exp_q.push_back(e);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + k); rx_last = (k == len-1);
      rx_err = (k == len-1) ? err : 5'h0;
      rx_bcast = (k == len-1) && bc; rx_mcast = (k == len-1) && mc;
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_err = 0; rx_bcast = 0; rx_mcast = 0;
  endtask

  task automatic drain;
    int t = 0;
    while (exp_q.size() != 0 && t < 500) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, "R6 write-back arrived", 32'(exp_q.size()), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic probe_parked(input int cyc, input string tag);
    bit seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (rx_ready || (mem_req && mem_we)) seen = 1;
    end
    check(!seen, tag, 32'(seen), 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NDESC; i++) init_desc(i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!mem_req && !rx_ready, "R1 idle after reset", {30'b0, mem_req, rx_ready}, 32'h0);

    // R1: stream waiting but engine not armed
    rx_valid = 1; rx_data = 8'h11;
    begin
      bit any = 0;
      repeat (12) begin @(negedge clk); if (mem_req || rx_ready) any = 1; end
      check(!any, "R1 no activity before arm", 32'(any), 32'h0);
    end
    rx_valid = 0;

    // R2: write without bit 24 ignored
    arm(32'hFEFF_FFFF);
    rx_valid = 1;
    begin
      bit any = 0;
      repeat (10) begin @(negedge clk); if (mem_req || rx_ready) any = 1; end
      check(!any, "R2 arm without bit 24 ignored", 32'(any), 32'h0);
    end
    rx_valid = 0;
    arm(32'h0100_0000);

    // R3 R5 R6: aligned frame, ring base low bits ignored
    send_frame(0, 16, 8'h10, 5'h00, 0, 0, "R3");
    drain();
    // R7 R8: short frame, crc error, broadcast, partial word
    send_frame(1, 7, 8'h40, 5'b00100, 1, 0, "R7 R8");
    drain();
    // R9: exactly max, multicast, several error flags
    send_frame(2, BUFMAX, 8'h80, 5'b10011, 0, 1, "R7 R8 R9");
    drain();
    // R9 R10: oversize into wrap descriptor
    send_frame(3, BUFMAX + 7, 8'hC0, 5'b01000, 0, 0, "R9 R10");
    drain();

    // R4: wrapped to descriptor 0, still owned by software
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h33;
    probe_parked(25, "R4 parks on owned descriptor");
    check(rd32(RING) == {16'h0800, 16'd16}, "R4 owned descriptor untouched", rd32(RING), {16'h0800, 16'd16});
    for (int i = 0; i < NDESC; i++) init_desc(i);
    probe_parked(15, "R4 no re-poll without arm");
    arm(32'h0100_0000);
    send_frame(0, 5, 8'h20, 5'h00, 1, 1, "R4 R10");
    drain();
    send_frame(1, 4, 8'h60, 5'b00001, 0, 0, "R7");
    drain();
    send_frame(2, 1, 8'h90, 5'h00, 0, 0, "R5");
    drain();
    check(rd32(RING + 8*3) == {16'hA000, 16'h0}, "R10 unused descriptor left free",
          rd32(RING + 8*3), {16'hA000, 16'h0});
    finish_run();
  end
endmodule